// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block watches the SCL and SDA lines of an I2C bus and reports bus START and STOP conditions. Each is qualified against a programmable time count in system clock cycles. Both lines are first brought into the clock domain through a short synchronizer chain. A START is an SDA falling edge while SCL is high. A STOP is an SDA rising edge while SCL is high. Either is accepted only if SCL had already been high for half the count, and it is confirmed only once SCL has stayed high for the full count after the edge. A bus-busy flag follows the confirmed conditions.

An 8-bit configuration word is loaded through a write strobe. It holds:
- the time count;
- the polarity and line choice for a sticky pin-edge interrupt request;
- a bit that doubles the set-up/hold length that a condition generator elsewhere in the controller reads from `gen_time`.

When the bus enable is low, the interrupt logic sees its pin as high. Switching the enable while the pin is low can therefore raise a request that software must clear.

Top module: `i2c_cond_detect`

## Requirements
- R1: After reset all outputs are 0 and the configuration word is 0.
- R2: On a clock with `cfg_we`=1 the configuration word loads `cfg_wdata`. The word holds the time count T in bits [4:0], the edge polarity in bit 5 (1 = rising, 0 = falling), the monitored pin in bit 6 (1 = SDA, 0 = SCL) and the long generation length in bit 7.
- R3: `gen_time` equals T when bit 7 is 0 and 2·T when bit 7 is 1.
- R4: A zero or odd T is invalid, and no START or STOP pulse is produced while it is loaded.
- R5: For a valid T, suppose SDA falls while SCL has long been high and SCL stays high. `start_pulse` is then high for exactly one cycle, seen T+3 clocks after the SDA change.
- R6: An SDA edge is discarded in two cases. The first is SCL having been high for fewer than T/2 synchronized cycles before the edge. The second is SCL going low before T cycles have passed after the edge.
- R7: An SDA rising edge with SCL high is qualified in the same way and gives a one-cycle `stop_pulse` T+3 clocks after the SDA change.
- R8: `bus_busy` rises the clock after `start_pulse`. It falls the clock after `stop_pulse`, or the clock after `bus_en` is 0.
- R9: Conditions are detected only while `bus_en` is 1, starting with the first clock at which it is 1.
- R10: `pin_irq` is set 3 clocks after a change of the monitored pin in the selected direction. A change in the other direction leaves it unchanged.
- R11: `pin_irq` stays set until a clock with `irq_clr`=1. If a qualifying edge arrives on that same clock, the flag stays set.
- R12: While `bus_en` is 0 the interrupt logic treats the monitored pin as 1. Setting `bus_en` while that pin is low is therefore a falling edge.
- R13: SDA changes made while SCL is low produce no START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus interface enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| irq_clr | input | 1 | Clear strobe for the pin interrupt request |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| start_pulse | output | 1 | One-cycle START indication |
| stop_pulse | output | 1 | One-cycle STOP indication |
| bus_busy | output | 1 | Bus held between START and STOP |
| pin_irq | output | 1 | Sticky pin-edge interrupt request |
| gen_time | output | 6 | Set-up/hold length for generated conditions |

## Verification
A qualifier counter that is off by one shows as a START or STOP pulse one clock early or late. Each pulse has a fixed latency of T+3 clocks, so the bench measures that latency exactly instead of looking for the pulse somewhere in a window. A qualifier that stays in its waiting state after SCL drops shows as a false pulse within T clocks of SCL returning high. A stale busy flag shows on the next disable or STOP. A wrong gated-pin register shows at once as a missing or spurious `pin_irq` three clocks after a line change, or after an enable toggle.

// File: rtl/i2c_cond_pkg.sv
// Shared types for the I2C bus condition detector.
// Assumes a 5-bit time count; the configuration word is 8 bits wide.
package i2c_cond_pkg;
    localparam int TIME_W = 5;

    typedef enum logic {
        Q_IDLE,
        Q_WAIT
    } qual_state_e;

    typedef struct packed {
        logic              gen_long;
        logic              pin_sda;
        logic              pol_rise;
        logic [TIME_W-1:0] tcount;
    } cond_cfg_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchronizer for a group of asynchronous lines.
// Assumes idle lines are high, so each stage resets to 1.
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        logic [STAGES-1:0] chain;

        // shift the raw line through the synchronizer stages
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw_in[b]};
        end

        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_cond_qual.sv
// Qualifies one kind of SDA edge (START or STOP) against the SCL high time.
// Assumes limit is even and non-zero whenever active is 1.
module i2c_cond_qual
    import i2c_cond_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          sda_edge,
    input  logic          scl_s,
    input  logic          scl_hi_ok,
    input  logic [TW-1:0] limit,
    output logic          cond_pulse
);
    qual_state_e   state;
    logic [TW-1:0] wait_cnt;
    logic [TW-1:0] last_cnt;

    assign last_cnt = TW'(limit - 1'b1);

    // wait for SCL to stay high for limit cycles after a qualified edge
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state      <= Q_IDLE;
            wait_cnt   <= '0;
            cond_pulse <= 1'b0;
        end else begin
            cond_pulse <= 1'b0;
            case (state)
                Q_IDLE: begin
                    if (sda_edge && scl_s && scl_hi_ok) begin
                        state    <= Q_WAIT;
                        wait_cnt <= '0;
                    end
                end
                Q_WAIT: begin
                    if (!scl_s) begin
                        state <= Q_IDLE;
                    end else if (wait_cnt == last_cnt) begin
                        state      <= Q_IDLE;
                        cond_pulse <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= Q_IDLE;
            endcase
        end
    end

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !cond_pulse);
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cond_pulse |=> !cond_pulse);
    assert_scl_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cond_pulse |-> $past(scl_s));
endmodule

// File: rtl/i2c_pin_irq.sv
// Sticky edge interrupt request on a chosen bus line.
// Assumes synchronized inputs; the pin reads as 1 while the bus is disabled.
module i2c_pin_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_en,
    input  logic scl_s,
    input  logic sda_s,
    input  logic pin_sda,
    input  logic pol_rise,
    input  logic irq_clr,
    output logic irq
);
    logic pin_now;
    logic pin_prev;
    logic edge_hit;

    assign pin_now  = bus_en ? (pin_sda ? sda_s : scl_s) : 1'b1;
    assign edge_hit = pol_rise ? (pin_now & ~pin_prev) : (~pin_now & pin_prev);

    // remember the gated pin level of the previous clock
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b1;
        else        pin_prev <= pin_now;
    end

    // set on a selected edge, clear on strobe, edge wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (edge_hit) irq <= 1'b1;
        else if (irq_clr)  irq <= 1'b0;
    end

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);
endmodule

// File: rtl/i2c_cond_detect.sv
// Top of the I2C START/STOP detector: configuration word, line synchronizers,
// SCL high-time counter, START and STOP qualifiers, busy flag and pin interrupt.
// Assumes a single clock domain and a synchronous active-low reset.
module i2c_cond_detect
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              irq_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              bus_busy,
    output logic              pin_irq,
    output logic [TIME_W:0]   gen_time
);
    localparam int TW = TIME_W;
    localparam logic [TW-1:0] HI_MAX = '1;

    cond_cfg_t     cfg;
    logic [1:0]    lines_s;
    logic          scl_s;
    logic          sda_s;
    logic          sda_d;
    logic [TW-1:0] scl_hi_cnt;
    logic          cfg_valid;
    logic          active;
    logic          scl_hi_ok;
    logic          sda_fall;
    logic          sda_rise;

    // load the configuration word on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_we) cfg <= cond_cfg_t'(cfg_wdata);
    end

    i2c_line_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({sda_in, scl_in}),
        .sync_out (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    // keep the previous SDA level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_d <= 1'b1;
        else        sda_d <= sda_s;
    end

    // count consecutive SCL-high cycles, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !scl_s)      scl_hi_cnt <= '0;
        else if (scl_hi_cnt != HI_MAX) scl_hi_cnt <= scl_hi_cnt + 1'b1;
    end

    assign cfg_valid = (cfg.tcount != '0) && !cfg.tcount[0];
    assign active    = bus_en && cfg_valid;
    assign scl_hi_ok = scl_hi_cnt >= (cfg.tcount >> 1);
    assign sda_fall  = sda_d & ~sda_s;
    assign sda_rise  = ~sda_d & sda_s;

    i2c_cond_qual #(.TW(TW)) u_start_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .sda_edge   (sda_fall),
        .scl_s      (scl_s),
        .scl_hi_ok  (scl_hi_ok),
        .limit      (cfg.tcount),
        .cond_pulse (start_pulse)
    );

    i2c_cond_qual #(.TW(TW)) u_stop_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .sda_edge   (sda_rise),
        .scl_s      (scl_s),
        .scl_hi_ok  (scl_hi_ok),
        .limit      (cfg.tcount),
        .cond_pulse (stop_pulse)
    );

    // track bus ownership between START and STOP
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_en) bus_busy <= 1'b0;
        else if (start_pulse)  bus_busy <= 1'b1;
        else if (stop_pulse)   bus_busy <= 1'b0;
    end

    i2c_pin_irq u_pin_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .pin_sda  (cfg.pin_sda),
        .pol_rise (cfg.pol_rise),
        .irq_clr  (irq_clr),
        .irq      (pin_irq)
    );

    assign gen_time = cfg.gen_long ? {cfg.tcount, 1'b0} : {1'b0, cfg.tcount};

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !bus_busy);
endmodule

// File: tb/test_i2c_cond_detect.sv
module test_i2c_cond_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       irq_clr = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       start_pulse, stop_pulse, bus_busy, pin_irq;
    logic [5:0] gen_time;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_cond_detect i_i2c_cond_detect (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .irq_clr(irq_clr), .scl_in(scl_in),
        .sda_in(sda_in), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .bus_busy(bus_busy), .pin_irq(pin_irq), .gen_time(gen_time)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    endtask

    // watch for up to 60 clocks; report first latency and number of pulses
    task automatic watch(input bit want_stop, output int lat, output int cnt);
        lat = -1; cnt = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (want_stop ? stop_pulse : start_pulse) begin
                cnt++;
                if (lat < 0) lat = i;
            end
        end
    endtask

    // idle bus with both lines high for a while
    task automatic idle_high();
        scl_in = 1'b0; cyc(2);
        sda_in = 1'b1; cyc(2);
        scl_in = 1'b1; cyc(40);
    endtask

    task automatic t_reset();
        chk("R1 start_pulse", start_pulse, 0);
        chk("R1 stop_pulse", stop_pulse, 0);
        chk("R1 bus_busy", bus_busy, 0);
        chk("R1 pin_irq", pin_irq, 0);
        chk("R1 gen_time", gen_time, 0);
    endtask

    task automatic t_gen_time();
        write_cfg(8'h08); chk("R3 short gen_time", gen_time, 8);
        write_cfg(8'h88); chk("R3 long gen_time", gen_time, 16);
        write_cfg(8'h96); chk("R2 R3 long gen_time T=22", gen_time, 44);
        write_cfg(8'h08);
    endtask

    task automatic t_start_stop();
        int lat, cnt;
        idle_high();
        sda_in = 1'b0;
        watch(1'b0, lat, cnt);
        chk("R5 start latency", lat, 11);
        chk("R5 start pulse count", cnt, 1);
        chk("R8 busy after start", bus_busy, 1);
        sda_in = 1'b1;
        watch(1'b1, lat, cnt);
        chk("R7 stop latency", lat, 11);
        chk("R7 stop pulse count", cnt, 1);
        chk("R8 busy after stop", bus_busy, 0);
    endtask

    task automatic t_low_data();
        int lat, cnt, tot;
        idle_high();
        scl_in = 1'b0; cyc(3);
        tot = 0;
        sda_in = 1'b0; cyc(3);
        sda_in = 1'b1; cyc(3);
        sda_in = 1'b0;
        watch(1'b0, lat, cnt); tot += cnt;
        sda_in = 1'b1;
        watch(1'b1, lat, cnt); tot += cnt;
        chk("R13 no condition with SCL low", tot, 0);
    endtask

    task automatic t_short_hold();
        int lat, cnt;
        scl_in = 1'b0; cyc(2);
        sda_in = 1'b1; cyc(4);
        scl_in = 1'b1; cyc(1);
        sda_in = 1'b0;
        watch(1'b0, lat, cnt);
        chk("R6 short SCL-high before edge rejected", cnt, 0);
        scl_in = 1'b0; cyc(2);
    endtask

    task automatic t_abort();
        int lat, cnt;
        idle_high();
        sda_in = 1'b0; cyc(4);
        scl_in = 1'b0;
        watch(1'b0, lat, cnt);
        chk("R6 SCL drop aborts start", cnt, 0);
    endtask

    task automatic t_invalid(input logic [7:0] v, input string tag);
        int lat, cnt;
        write_cfg(v);
        idle_high();
        sda_in = 1'b0;
        watch(1'b0, lat, cnt);
        chk(tag, cnt + int'(bus_busy), 0);
        write_cfg(8'h08);
    endtask

    task automatic t_enable();
        int lat, cnt;
        write_cfg(8'h08);
        idle_high();
        sda_in = 1'b0;
        watch(1'b0, lat, cnt);
        chk("R8 busy set before disable", bus_busy, 1);
        bus_en = 1'b0; cyc(1);
        chk("R8 busy cleared by disable", bus_busy, 0);
        write_cfg(8'h02);
        idle_high();
        sda_in = 1'b0;
        watch(1'b0, lat, cnt);
        chk("R9 no start while disabled", cnt, 0);
        idle_high();
        bus_en = 1'b1;
        sda_in = 1'b0;
        watch(1'b0, lat, cnt);
        chk("R9 start right after enable T=2", lat, 5);
    endtask

    task automatic t_pin_irq();
        write_cfg(8'h60);
        sda_in = 1'b0; cyc(6);
        clear_irq();
        chk("R11 clear strobe", pin_irq, 0);
        sda_in = 1'b1; cyc(2);
        chk("R10 not yet set", pin_irq, 0);
        cyc(1);
        chk("R10 rising SDA sets irq", pin_irq, 1);
        cyc(5);
        chk("R11 irq held", pin_irq, 1);
        clear_irq();
        sda_in = 1'b0; cyc(6);
        chk("R10 falling edge ignored", pin_irq, 0);
        sda_in = 1'b1; cyc(6);
        sda_in = 1'b0; cyc(2);
        irq_clr = 1'b1;
        sda_in = 1'b1; cyc(2);
        irq_clr = 1'b1; cyc(1);
        irq_clr = 1'b0;
        chk("R11 edge beats clear", pin_irq, 1);
    endtask

    task automatic t_enable_irq();
        write_cfg(8'h00);
        bus_en = 1'b0;
        scl_in = 1'b0; cyc(6);
        clear_irq(); cyc(2);
        chk("R12 no irq while disabled", pin_irq, 0);
        bus_en = 1'b1; cyc(2);
        chk("R12 enable with SCL low sets irq", pin_irq, 1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_gen_time();
        bus_en = 1'b1;
        t_start_stop();
        t_low_data();
        t_short_hold();
        t_abort();
        t_invalid(8'h07, "R4 odd count gives no start");
        t_invalid(8'h00, "R4 zero count gives no start");
        t_enable();
        t_pin_irq();
        t_enable_irq();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule